// File: doc/BRIEF.md
# Push-Button Step Counter

This block keeps a 16-bit count that four push buttons move up or down, either by one or by an operand read from a 16-bit switch bank. A fifth, centre button clears the count. The output is meant to drive a row of LEDs directly.

Each of the four step buttons is handled on its own path. A two-stage flip-flop synchronizer brings the button into the clock domain. A rising-edge detector then turns each press into a pulse that lasts one cycle. The pulses are ranked by a fixed priority and applied to the count on the next clock edge. The switch operand is not registered. It is read in the same cycle that its add or subtract pulse takes effect.

Top module: `step_counter`

## Requirements
- R1: A press of the increment button (`inc_btn`) raises the count by exactly one.
- R2: A press of the decrement button (`dec_btn`) lowers the count by exactly one.
- R3: A press of the add button (`add_btn`) adds the 16-bit switch word to the count.
- R4: A press of the subtract button (`sub_btn`) subtracts the 16-bit switch word from the count.
- R5: A button held high for any number of cycles changes the count only once.
- R6: While `clr_btn` is high at a rising clock edge, the count becomes zero. This takes priority over every step button.
- R7: The count wraps modulo 65536 in both directions. It never saturates.
- R8: When several step pulses occur in the same cycle, only one is applied. The order of precedence is increment, then decrement, then add, then subtract.
- R9: If a step button goes high before rising edge k, the count changes at edge k+2 and at no other edge. At all other times the count holds its value.
- R10: The add and subtract operations use the switch word as it is at the clock edge where the count changes, not its value when the button was pressed.
- R11: A clear empties every synchronizer and edge-detect stage. A button held high through the clear is therefore taken as one new press after `clr_btn` falls, and the count changes at the third edge after the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr_btn | input | 1 | Centre button, synchronous clear of the count and the button pipelines |
| inc_btn | input | 1 | Step up by one |
| dec_btn | input | 1 | Step down by one |
| add_btn | input | 1 | Add the switch word |
| sub_btn | input | 1 | Subtract the switch word |
| sw | input | 16 | Switch operand |
| count | output | 16 | Present count |

## Verification
The hardest condition to reach is two or more step pulses landing in the same cycle. The synchronizer delay hides this from the ports, so the buttons must rise between the same pair of edges. The bench drives several buttons at one falling edge, and it also runs a long random stretch where buttons toggle independently, so collisions happen in many combinations. The switch word is changed every cycle while a press works through the pipeline, so an operand sampled too early shows up as a mismatch. A button held across the clear covers the pipeline reset.

// File: rtl/step_counter.sv
module step_counter #(
  parameter int W    = 16,
  parameter int NBTN = 4
) (
  input  logic         clk,
  input  logic         clr_btn,
  input  logic         inc_btn,
  input  logic         dec_btn,
  input  logic         add_btn,
  input  logic         sub_btn,
  input  logic [W-1:0] sw,
  output logic [W-1:0] count
);

  localparam int UP = 0, DN = 1, AD = 2, SB = 3;

  logic [NBTN-1:0] raw, meta, sync, last, pulse;
  logic [W-1:0]    cnt_q, cnt_d;

  assign raw = {sub_btn, add_btn, dec_btn, inc_btn};

  for (genvar b = 0; b < NBTN; b++) begin : g_btn
    always_ff @(posedge clk) begin
      if (clr_btn) begin
        meta[b] <= 1'b0;
        sync[b] <= 1'b0;
        last[b] <= 1'b0;
      end else begin
        meta[b] <= raw[b];
        sync[b] <= meta[b];
        last[b] <= sync[b];
      end
    end
    assign pulse[b] = sync[b] & ~last[b];

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (clr_btn)
      pulse[b] |=> !pulse[b]);
  end

  always_comb begin
    cnt_d = cnt_q;
    if      (pulse[UP]) cnt_d = cnt_q + W'(1);
    else if (pulse[DN]) cnt_d = cnt_q - W'(1);
    else if (pulse[AD]) cnt_d = cnt_q + sw;
    else if (pulse[SB]) cnt_d = cnt_q - sw;
  end

  always_ff @(posedge clk) begin
    if (clr_btn) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r6_clear: assert property (@(posedge clk)
    clr_btn |=> count == '0);

  a_r1_inc: assert property (@(posedge clk) disable iff (clr_btn)
    pulse[UP] |=> count == W'($past(count) + W'(1)));

  a_r2_dec: assert property (@(posedge clk) disable iff (clr_btn)
    (pulse[DN] && !pulse[UP]) |=> count == W'($past(count) - W'(1)));

  a_r3_add: assert property (@(posedge clk) disable iff (clr_btn)
    (pulse[AD] && !pulse[UP] && !pulse[DN]) |=> count == W'($past(count) + $past(sw)));

  a_r4_sub: assert property (@(posedge clk) disable iff (clr_btn)
    (pulse[SB] && !pulse[UP] && !pulse[DN] && !pulse[AD])
      |=> count == W'($past(count) - $past(sw)));

  a_r9_hold: assert property (@(posedge clk) disable iff (clr_btn)
    (pulse == '0) |=> $stable(count));

  a_r11_pipe_clear: assert property (@(posedge clk)
    clr_btn |=> (pulse == '0));

endmodule

// File: tb/step_counter_tb.sv
module step_counter_tb_top;
  logic        clk = 1'b0;
  logic        clr_btn = 1'b1;
  logic        inc_btn = 1'b0, dec_btn = 1'b0, add_btn = 1'b0, sub_btn = 1'b0;
  logic [15:0] sw = '0;
  logic [15:0] count;

  int checks = 0, errors = 0, cycles = 0;
  string phase = "R6 reset";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  step_counter dut_i (
    .clk(clk), .clr_btn(clr_btn), .inc_btn(inc_btn), .dec_btn(dec_btn),
    .add_btn(add_btn), .sub_btn(sub_btn), .sw(sw), .count(count)
  );

  // reference model: input history per button, h1 = newest
  logic [3:0]  h1 = '0, h2 = '0, h3 = '0;
  logic [15:0] m_count = '0;
  bit          m_valid = 1'b0;

  always @(posedge clk) begin
    logic [3:0] p;
    p = h2 & ~h3;
    if (clr_btn) begin
      m_count = '0;
      m_valid = 1'b1;
      h1 = '0; h2 = '0; h3 = '0;
    end else begin
      if      (p[0]) m_count = m_count + 16'd1;
      else if (p[1]) m_count = m_count - 16'd1;
      else if (p[2]) m_count = m_count + sw;
      else if (p[3]) m_count = m_count - sw;
      h3 = h2; h2 = h1;
      h1 = {sub_btn, add_btn, dec_btn, inc_btn};
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (m_valid && !done) begin
      checks++;
      if (count !== m_count) begin
        errors++;
        $display("FAIL %s: count=%h expected=%h", phase, count, m_count);
      end
    end
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected=<100000", cycles);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(int b, int hold);
    @(negedge clk);
    case (b)
      0: inc_btn = 1'b1;
      1: dec_btn = 1'b1;
      2: add_btn = 1'b1;
      default: sub_btn = 1'b1;
    endcase
    idle(hold);
    {sub_btn, add_btn, dec_btn, inc_btn} = '0;
    idle(4);
  endtask

  initial begin
    idle(3);
    clr_btn = 1'b0;
    idle(2);

    phase = "R1 increment";
    for (int i = 0; i < 3; i++) press(0, 1);

    phase = "R2 decrement";
    for (int i = 0; i < 2; i++) press(1, 2);

    phase = "R7 wrap below zero";
    for (int i = 0; i < 3; i++) press(1, 1);

    phase = "R3 add switch";
    sw = 16'h1234;
    for (int i = 0; i < 3; i++) press(2, 1);

    phase = "R4 subtract switch";
    sw = 16'h0101;
    for (int i = 0; i < 3; i++) press(3, 1);

    phase = "R7 wrap above max";
    sw = 16'hF000;
    for (int i = 0; i < 2; i++) press(2, 1);

    phase = "R5 long hold";
    press(0, 25);
    press(3, 30);

    phase = "R9 latency";
    @(negedge clk); inc_btn = 1'b1;
    idle(2);
    idle(6); inc_btn = 1'b0; idle(4);

    phase = "R8 simultaneous";
    @(negedge clk); {sub_btn, add_btn, dec_btn, inc_btn} = 4'b1111; idle(3);
    {sub_btn, add_btn, dec_btn, inc_btn} = '0; idle(4);
    @(negedge clk); {sub_btn, add_btn, dec_btn} = 3'b111; idle(3);
    {sub_btn, add_btn, dec_btn, inc_btn} = '0; idle(4);
    @(negedge clk); {sub_btn, add_btn} = 2'b11; idle(3);
    {sub_btn, add_btn, dec_btn, inc_btn} = '0; idle(4);

    phase = "R10 late switch";
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); add_btn = (i % 2 == 0); sub_btn = (i % 2 == 1);
      for (int k = 0; k < 5; k++) begin
        sw = 16'($urandom);
        @(negedge clk);
      end
      add_btn = 1'b0; sub_btn = 1'b0; idle(3);
    end

    phase = "R6 clear over buttons";
    @(negedge clk); clr_btn = 1'b1; {sub_btn, add_btn, dec_btn, inc_btn} = 4'b1111;
    idle(4);
    {sub_btn, add_btn, dec_btn, inc_btn} = '0;
    @(negedge clk); clr_btn = 1'b0; idle(4);

    phase = "R11 held through clear";
    press(0, 1); press(0, 1);
    @(negedge clk); inc_btn = 1'b1; clr_btn = 1'b1; idle(3);
    clr_btn = 1'b0; idle(8);
    inc_btn = 1'b0; idle(4);

    phase = "R8 random mix";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      {sub_btn, add_btn, dec_btn, inc_btn} = 4'($urandom);
      sw = 16'($urandom);
      clr_btn = ($urandom % 200 == 0);
    end
    clr_btn = 1'b0;
    {sub_btn, add_btn, dec_btn, inc_btn} = '0;
    idle(5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule